// File: doc/BRIEF.md
# Legacy Low-Memory Region Router

The block routes one physical address per request within a PC-style address space. It covers the first megabyte and the BIOS alias just below 4 GiB. For each accepted request it names the place that serves the access: main RAM, shadow RAM, the BIOS ROM, the expansion ROM, the VGA device, a floating bus that reads as 0xFF, or a veto that forbids direct access. For ROM targets it also returns the byte offset into a combined ROM image. In that image the BIOS ROM comes first and the expansion ROM follows it.

Reads, writes and instruction fetches to the same address may resolve differently. The result depends on the CPU's system-management mode, on three SMRAM control bits and on per-segment shadow attributes for the 0xC0000–0xFFFFF area. A small command port loads the SMRAM bits. An external MMIO-hit input represents every memory-mapped device range and overrides all other rules. The result is registered and appears one cycle after the request is accepted.

Top module: `lowmem_router`

## Requirements
- R1: While `rst_n` is low, `req_ready`, `rsp_valid` and `smram_data_ok` are 0, and the SMRAM available, enable and restricted bits are cleared.
- R2: From the first clock after reset, `req_ready` is 1. A request with `req_valid`=1 yields `rsp_valid`=1 with its result exactly one clock later. A clock with no request yields `rsp_valid`=0.
- R3: `req_op` encodes 0=data read, 1=data write, 2=instruction fetch and 3=read-modify-write. Code 3 is routed exactly as a write.
- R4: `rsp_target` encodes 0=RAM, 1=shadow RAM, 2=BIOS ROM, 3=expansion ROM, 4=VGA, 5=float (reads 0xFF) and 6=veto. When `mmio_hit`=1, the target is veto for every operation, whatever the other inputs are.
- R5: In 0xA0000–0xBFFFF, a data read goes to RAM when SMRAM is enabled or `req_smm`=1, and to VGA otherwise. A write goes to RAM only when SMRAM is enabled, and to VGA otherwise.
- R6: In 0xA0000–0xBFFFF, an instruction fetch goes to RAM only when SMRAM is available and either enabled or `req_smm`=1. Otherwise it goes to VGA.
- R7: A `cfg_we` pulse with `cfg_open`=1 sets available and loads enable from `cfg_enable` and restricted from `cfg_restrict`. With `cfg_open`=0, the pulse clears all three bits. The bits change at the clock edge after the pulse. A request sampled at that same edge uses the old values. `smram_data_ok` = available AND (enable OR NOT restricted).
- R8: A read or fetch in 0xC0000–0xFFFFF with `shadow_on`=1 goes to shadow RAM when `shadow_rd_attr[addr[17:14]]`=1, and to ROM when that bit is 0.
- R9: A ROM read in 0xE0000–0xFFFFF gives the BIOS ROM with offset addr[16:0]. A ROM read in 0xC0000–0xDFFFF gives the expansion ROM with offset 0x20000 + addr[16:0]. With `shadow_on`=0, reads and fetches in 0xC0000–0xFFFFF always go to ROM.
- R10: `rsp_rom_off` is 0 for every target other than BIOS and expansion ROM.
- R11: Any other read or fetch goes to:
  - RAM below the installed size (16 MiB by default);
  - the BIOS ROM with offset addr[16:0] at or above 0xFFFE0000;
  - float with `rsp_oor`=1 everywhere else.

  `rsp_oor` is 1 for the float target and 0 for all others.
- R12: Writes at or above the installed size, writes in 0xC0000–0xFFFFF and writes at or above 0xFFFE0000 are vetoed. All other writes outside 0xA0000–0xBFFFF go to RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request |
| req_addr | input | ADDR_W (32) | Physical address |
| req_op | input | 2 | Operation code (R3) |
| req_smm | input | 1 | CPU is in system-management mode |
| mmio_hit | input | 1 | Address hits a memory-mapped device |
| shadow_on | input | 1 | Shadow attributes in force for 0xC0000–0xFFFFF |
| shadow_rd_attr | input | SEG_CNT (16) | Read attribute per 16 KiB segment, 1 = shadow RAM |
| cfg_we | input | 1 | SMRAM command strobe |
| cfg_open | input | 1 | 1 = make SMRAM available, 0 = clear all bits |
| cfg_enable | input | 1 | Enable value loaded on open |
| cfg_restrict | input | 1 | Restricted value loaded on open |
| smram_data_ok | output | 1 | SMRAM usable for data accesses |
| rsp_valid | output | 1 | Result present |
| rsp_target | output | 3 | Target code (R4) |
| rsp_rom_off | output | OFF_W (18) | Offset into combined ROM image |
| rsp_oor | output | 1 | Read falls outside any backing store |

## Verification
The clocked properties assume that every request input is at a known value whenever `req_valid` is high. They also assume that `cfg_*` inputs matter only in a cycle where `cfg_we` is set. The stimulus keeps to this: it drives every input on the falling edge, from a fixed seed, with addresses drawn from classes that straddle each region edge, and op codes limited to the four defined values. Command pulses are mixed into request cycles. Each request is therefore checked against the SMRAM state as it stood before that edge.

// File: rtl/lowmem_pkg.sv
// Shared encodings for the low-memory router.
// Assumes: encodings are visible at the top-level ports, so they must stay fixed.
package lowmem_pkg;
    typedef enum logic [2:0] {
        TGT_RAM    = 3'd0,
        TGT_SHADOW = 3'd1,
        TGT_BIOS   = 3'd2,
        TGT_EXPROM = 3'd3,
        TGT_VGA    = 3'd4,
        TGT_FLOAT  = 3'd5,
        TGT_VETO   = 3'd6
    } target_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FETCH = 2'd2,
        OP_RMW   = 2'd3
    } op_e;
endpackage

// File: rtl/lowmem_smram_ctl.sv
// SMRAM control bits loaded by a command strobe.
// Assumes: the cfg_* value inputs are meaningful only while cfg_we is high.
module lowmem_smram_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_open,
    input  logic cfg_enable,
    input  logic cfg_restrict,
    output logic sm_avail,
    output logic sm_en,
    output logic sm_data_ok
);
    logic sm_restr;

    // Hold or reload the three control bits on a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sm_avail <= 1'b0;
            sm_en    <= 1'b0;
            sm_restr <= 1'b0;
        end else if (cfg_we) begin
            sm_avail <= cfg_open;
            sm_en    <= cfg_open & cfg_enable;
            sm_restr <= cfg_open & cfg_restrict;
        end
    end

    // Data accesses may use SMRAM when it is open and unlocked.
    always_comb sm_data_ok = sm_avail & (sm_en | ~sm_restr);

    // R7
    smram_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_open) |=> !sm_data_ok);
    // R7
    smram_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_open && cfg_enable) |=> (sm_data_ok && sm_avail));
endmodule

// File: rtl/lowmem_decode.sv
// Combinational region decoder: classifies the address and applies the
// operation, SMM, SMRAM and shadow rules in a fixed priority.
// Assumes: MEM_MB >= 1, SEG_CNT is a power of two between 2 and 256,
// BIOS_BYTES and EXP_BYTES are powers of two no larger than 128 KiB.
module lowmem_decode
    import lowmem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MEM_MB     = 16,
    parameter int BIOS_BYTES = 131072,
    parameter int EXP_BYTES  = 131072,
    parameter int SEG_CNT    = 16,
    parameter int OFF_W      = 18
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         op,
    input  logic               smm,
    input  logic               mmio,
    input  logic               shadow_on,
    input  logic [SEG_CNT-1:0] shadow_attr,
    input  logic               sm_avail,
    input  logic               sm_en,
    output target_e            tgt,
    output logic [OFF_W-1:0]   off,
    output logic               err
);
    localparam int SEG_IDX_W = $clog2(SEG_CNT);
    localparam int SEG_SHIFT = 18 - SEG_IDX_W;
    localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_MB) << 20;
    localparam logic [ADDR_W:0] TOP_BASE  = {1'b1, {ADDR_W{1'b0}}} - (ADDR_W+1)'(BIOS_BYTES);
    localparam logic [ADDR_W-1:0] BIOS_MASK = ADDR_W'(BIOS_BYTES - 1);
    localparam logic [ADDR_W-1:0] EXP_MASK  = ADDR_W'(EXP_BYTES - 1);

    logic               in_win, in_rom, below_mem, in_top, is_wr, is_fx;
    logic [SEG_CNT-1:0] seg_pick;
    logic               attr_sel;
    target_e            rom_tgt;
    logic [OFF_W-1:0]   rom_off;

    // One comparator per shadow segment picks the attribute bit.
    for (genvar i = 0; i < SEG_CNT; i++) begin : g_seg
        assign seg_pick[i] = (addr[17:SEG_SHIFT] == SEG_IDX_W'(i)) & shadow_attr[i];
    end

    // Classify the address and the operation.
    always_comb begin
        in_win    = addr[ADDR_W-1:17] == (ADDR_W-17)'(5);
        in_rom    = addr[ADDR_W-1:18] == (ADDR_W-18)'(3);
        below_mem = {1'b0, addr} < MEM_LIMIT;
        in_top    = {1'b0, addr} >= TOP_BASE;
        is_wr     = op[0];
        is_fx     = (op == OP_FETCH);
        attr_sel  = |seg_pick;
    end

    // Select BIOS or expansion ROM and its offset in the combined image.
    always_comb begin
        if (addr[17]) begin
            rom_tgt = TGT_BIOS;
            rom_off = OFF_W'(addr & BIOS_MASK);
        end else begin
            rom_tgt = TGT_EXPROM;
            rom_off = OFF_W'(BIOS_BYTES) + OFF_W'(addr & EXP_MASK);
        end
    end

    // Apply the routing rules in priority order.
    always_comb begin
        tgt = TGT_VETO;
        off = '0;
        err = 1'b0;
        if (mmio) begin
            tgt = TGT_VETO;
        end else if (in_win) begin
            if (is_fx)
                tgt = (sm_avail && (sm_en || smm)) ? TGT_RAM : TGT_VGA;
            else if (is_wr)
                tgt = sm_en ? TGT_RAM : TGT_VGA;
            else
                tgt = (sm_en || smm) ? TGT_RAM : TGT_VGA;
        end else if (is_wr) begin
            if (!below_mem || in_top || in_rom)
                tgt = TGT_VETO;
            else
                tgt = TGT_RAM;
        end else if (in_rom) begin
            if (shadow_on && attr_sel) begin
                tgt = TGT_SHADOW;
            end else begin
                tgt = rom_tgt;
                off = rom_off;
            end
        end else if (below_mem) begin
            tgt = TGT_RAM;
        end else if (in_top) begin
            tgt = TGT_BIOS;
            off = OFF_W'(addr & BIOS_MASK);
        end else begin
            tgt = TGT_FLOAT;
            err = 1'b1;
        end
    end
endmodule

// File: rtl/lowmem_resp_reg.sv
// Request acceptance and the result register stage.
// Assumes: the result of a request is wanted one cycle after acceptance, and
// the consumer does not stall.
module lowmem_resp_reg
    import lowmem_pkg::*;
#(
    parameter int OFF_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             acc_mmio,
    input  logic             acc_wr,
    input  target_e          d_tgt,
    input  logic [OFF_W-1:0] d_off,
    input  logic             d_err,
    output logic             rsp_valid,
    output target_e          rsp_tgt,
    output logic [OFF_W-1:0] rsp_off,
    output logic             rsp_err
);
    logic acc;

    // A request is taken whenever it meets ready.
    always_comb acc = req_valid & req_ready;

    // Raise ready after reset and capture the decoded route on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_tgt   <= TGT_VETO;
            rsp_off   <= '0;
            rsp_err   <= 1'b0;
        end else begin
            req_ready <= 1'b1;
            rsp_valid <= acc;
            if (acc) begin
                rsp_tgt <= d_tgt;
                rsp_off <= d_off;
                rsp_err <= d_err;
            end
        end
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));
    // R4
    mmio_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_mmio) |=> (rsp_valid && rsp_tgt == TGT_VETO));
    // R12
    write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_wr) |=> (rsp_tgt == TGT_RAM || rsp_tgt == TGT_VGA || rsp_tgt == TGT_VETO));
    // R10
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_tgt != TGT_BIOS && rsp_tgt != TGT_EXPROM) |-> (rsp_off == '0));
    // R11
    float_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err == (rsp_tgt == TGT_FLOAT)));
endmodule

// File: rtl/lowmem_router.sv
// Top level: SMRAM control, region decoder and result register.
// Assumes: MEM_MB is the installed size in whole MiB, at least 1.
module lowmem_router
    import lowmem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MEM_MB     = 16,
    parameter int BIOS_BYTES = 131072,
    parameter int EXP_BYTES  = 131072,
    parameter int SEG_CNT    = 16,
    parameter int OFF_W      = $clog2(BIOS_BYTES + EXP_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_op,
    input  logic               req_smm,
    input  logic               mmio_hit,
    input  logic               shadow_on,
    input  logic [SEG_CNT-1:0] shadow_rd_attr,
    input  logic               cfg_we,
    input  logic               cfg_open,
    input  logic               cfg_enable,
    input  logic               cfg_restrict,
    output logic               smram_data_ok,
    output logic               rsp_valid,
    output logic [2:0]         rsp_target,
    output logic [OFF_W-1:0]   rsp_rom_off,
    output logic               rsp_oor
);
    logic             sm_avail, sm_en;
    target_e          d_tgt, q_tgt;
    logic [OFF_W-1:0] d_off;
    logic             d_err;

    lowmem_smram_ctl u_smram (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_open(cfg_open),
        .cfg_enable(cfg_enable), .cfg_restrict(cfg_restrict),
        .sm_avail(sm_avail), .sm_en(sm_en), .sm_data_ok(smram_data_ok)
    );

    lowmem_decode #(
        .ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .BIOS_BYTES(BIOS_BYTES),
        .EXP_BYTES(EXP_BYTES), .SEG_CNT(SEG_CNT), .OFF_W(OFF_W)
    ) u_dec (
        .addr(req_addr), .op(req_op), .smm(req_smm), .mmio(mmio_hit),
        .shadow_on(shadow_on), .shadow_attr(shadow_rd_attr),
        .sm_avail(sm_avail), .sm_en(sm_en),
        .tgt(d_tgt), .off(d_off), .err(d_err)
    );

    lowmem_resp_reg #(.OFF_W(OFF_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .acc_mmio(mmio_hit), .acc_wr(req_op[0]),
        .d_tgt(d_tgt), .d_off(d_off), .d_err(d_err),
        .rsp_valid(rsp_valid), .rsp_tgt(q_tgt),
        .rsp_off(rsp_rom_off), .rsp_err(rsp_oor)
    );

    // Present the target code as a plain vector.
    always_comb rsp_target = q_tgt;
endmodule

// File: tb/lowmem_router_tb.sv
module lowmem_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic        req_smm = 1'b0;
    logic        mmio_hit = 1'b0;
    logic        shadow_on = 1'b0;
    logic [15:0] shadow_rd_attr = '0;
    logic        cfg_we = 1'b0, cfg_open = 1'b0, cfg_enable = 1'b0, cfg_restrict = 1'b0;
    logic        smram_data_ok, rsp_valid, rsp_oor;
    logic [2:0]  rsp_target;
    logic [17:0] rsp_rom_off;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic m_av = 1'b0, m_en = 1'b0, m_rs = 1'b0;

    always #2.5 clk = ~clk;

    lowmem_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_smm(req_smm), .mmio_hit(mmio_hit),
        .shadow_on(shadow_on), .shadow_rd_attr(shadow_rd_attr),
        .cfg_we(cfg_we), .cfg_open(cfg_open), .cfg_enable(cfg_enable),
        .cfg_restrict(cfg_restrict), .smram_data_ok(smram_data_ok),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_rom_off(rsp_rom_off),
        .rsp_oor(rsp_oor)
    );

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // Expected route from the requirements, with the tag of the rule used.
    function automatic void model(input logic [31:0] a, input logic [1:0] op, input logic smm,
                                  input logic mmio, input logic shon, input logic [15:0] attr,
                                  output logic [2:0] t, output logic [17:0] off,
                                  output logic err, output string tag);
        logic wr, fx, win, rom;
        wr = op[0];
        fx = (op == 2'd2);
        win = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
        rom = (a >= 32'h000C_0000) && (a <= 32'h000F_FFFF);
        t = 3'd6; off = '0; err = 1'b0; tag = "R4";
        if (mmio) begin
            t = 3'd6; tag = "R4";
        end else if (win) begin
            if (fx) begin t = (m_av && (m_en || smm)) ? 3'd0 : 3'd4; tag = "R6"; end
            else if (wr) begin t = m_en ? 3'd0 : 3'd4; tag = "R5"; end
            else begin t = (m_en || smm) ? 3'd0 : 3'd4; tag = "R5"; end
        end else if (wr) begin
            tag = (op == 2'd3) ? "R3" : "R12";
            t = (a >= 32'h0100_0000 || rom) ? 3'd6 : 3'd0;
        end else if (rom) begin
            if (shon && attr[a[17:14]]) begin t = 3'd1; tag = "R8"; end
            else if (a[17]) begin t = 3'd2; off = {1'b0, a[16:0]}; tag = "R9"; end
            else begin t = 3'd3; off = 18'h20000 + {1'b0, a[16:0]}; tag = "R9"; end
        end else if (a < 32'h0100_0000) begin
            t = 3'd0; tag = "R11";
        end else if (a >= 32'hFFFE_0000) begin
            t = 3'd2; off = {1'b0, a[16:0]}; tag = "R11";
        end else begin
            t = 3'd5; err = 1'b1; tag = "R11";
        end
    endfunction

    // One request (optionally with a command), checked one clock later.
    task automatic do_req(input logic [31:0] a, input logic [1:0] op, input logic smm,
                          input logic mmio, input logic shon, input logic [15:0] attr,
                          input logic we, input logic opn, input logic en, input logic rs);
        logic [2:0] et; logic [17:0] eo; logic ee; string tag;
        model(a, op, smm, mmio, shon, attr, et, eo, ee, tag);
        req_valid = 1'b1; req_addr = a; req_op = op; req_smm = smm; mmio_hit = mmio;
        shadow_on = shon; shadow_rd_attr = attr;
        cfg_we = we; cfg_open = opn; cfg_enable = en; cfg_restrict = rs;
        @(negedge clk);
        if (we) begin m_av = opn; m_en = opn & en; m_rs = opn & rs; end
        req_valid = 1'b0; cfg_we = 1'b0;
        check("R2", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check(tag, "target", {29'd0, rsp_target}, {29'd0, et});
        check("R10", "rom_off", {14'd0, rsp_rom_off}, {14'd0, eo});
        check("R11", "oor", {31'd0, rsp_oor}, {31'd0, ee});
        check("R7", "smram_data_ok", {31'd0, smram_data_ok}, {31'd0, m_av & (m_en | ~m_rs)});
    endtask

    function automatic logic [31:0] pick_addr();
        case ($urandom % 7)
            0: return 32'h000A_0000 + ($urandom % 32'h2_0000);
            1: return 32'h000C_0000 + ($urandom % 32'h4_0000);
            2: return $urandom % 32'h000A_0000;
            3: return 32'h0010_0000 + ($urandom % 32'h00F0_0000);
            4: return 32'h0100_0000 + ($urandom % 32'h1000) - 32'h800;
            5: return 32'hFFFE_0000 + ($urandom % 32'h2_0000) - 32'h100;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "req_ready", {31'd0, req_ready}, 32'd0);
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1", "smram_data_ok", {31'd0, smram_data_ok}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "req_ready", {31'd0, req_ready}, 32'd1);
        check("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // Directed corners, SMRAM closed.
        do_req(32'h0009_FFFF, 2'd0, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000A_0000, 2'd0, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000A_0000, 2'd0, 1, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000B_FFFF, 2'd2, 1, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000C_0000, 2'd0, 0, 0, 0, 16'hFFFF, 0, 0, 0, 0);
        do_req(32'h000D_FFFF, 2'd2, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000E_0000, 2'd0, 0, 0, 1, 16'h0, 0, 0, 0, 0);
        do_req(32'h000F_FFFF, 2'd0, 0, 0, 1, 16'h8000, 0, 0, 0, 0);
        do_req(32'h000C_4000, 2'd0, 0, 0, 1, 16'h0002, 0, 0, 0, 0);
        do_req(32'hFFFE_0000, 2'd0, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'hFFFD_FFFF, 2'd0, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h00FF_FFFF, 2'd0, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h0100_0000, 2'd2, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h0100_0000, 2'd1, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h00FF_FFFF, 2'd3, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000C_0000, 2'd1, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0);
        do_req(32'hFFFF_FFFF, 2'd3, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h0000_1000, 2'd0, 0, 1, 0, 16'h0, 0, 0, 0, 0);
        // Open SMRAM restricted and disabled, then probe with old and new state.
        do_req(32'h000A_0000, 2'd2, 0, 0, 0, 16'h0, 1, 1, 0, 1);
        do_req(32'h000A_0000, 2'd2, 1, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000A_0000, 2'd1, 1, 0, 0, 16'h0, 1, 1, 1, 0);
        do_req(32'h000A_0000, 2'd1, 0, 0, 0, 16'h0, 0, 0, 0, 0);
        do_req(32'h000A_0000, 2'd2, 0, 1, 0, 16'h0, 1, 0, 1, 1);
        do_req(32'h000A_0000, 2'd2, 1, 0, 0, 16'h0, 0, 0, 0, 0);
        @(negedge clk);
        check("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // Constrained random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic cw;
            cw = ($urandom % 8) == 0;
            do_req(pick_addr(), 2'($urandom), 1'($urandom), ($urandom % 10) == 0,
                   1'($urandom), 16'($urandom), cw, 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 16) == 0) begin
                @(negedge clk);
                check("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule